// File: doc/BRIEF.md
# Masked Sticky Error Status Aggregator

This block gathers single-cycle error pulses from the video checker and from the audio cores of a serial digital video receiver. Each pulse sets a sticky status bit. The status bits are gated by mask registers and folded into three registered, active-low flags: a video flag, an audio flag, and a combined data flag that reports either kind.

Software reaches the block through a small strobe-based register port. It writes the video mask and two audio masks, one for standard-definition operation and one for high-definition operation. It reads the two status words, and a read clears the word it returns. A field-start pulse also clears the status. Loss of lock, a low processing-enable input, a flagged change of video standard and reset clear all status bits unconditionally.

Top module: `err_status_agg`

## Requirements
- R1: After reset every mask register reads 0, so every error type is reported.
- R2: The three flags are high when nothing is reported. A flag changes one clock after the status or mask that drives it changes.
- R3: The video flag is low exactly when some video status bit is 1 while its video mask bit is 0. A mask bit of 1 suppresses that error type.
- R4: An event pulse sets its status bit. The bit then holds, with no further pulses, until a clear condition occurs.
- R5: A field-start pulse clears both status words. An event arriving in the same cycle as the field-start pulse stays set.
- R6: A read of a status address returns the pre-read value on host_rdata one cycle after the strobe, and that word is cleared at the same edge. An event arriving in the read cycle stays set.
- R7: Any of the following clears every status bit, including events in that same cycle: link_locked low, proc_enable low, std_change high, or rst high.
- R8: data_err_n is low exactly when vid_err_n or aud_err_n is low.
- R9: When hd_mode is 1 the HD audio mask gates the audio status, and when it is 0 the SD mask gates it. The unselected mask has no effect and keeps its value.
- R10: The address map is 0 video status, 1 audio status, 2 video mask, 3 SD audio mask and 4 HD audio mask. Addresses 5 to 7 read 0. Writes to the status addresses have no effect, and mask reads clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_err_evt | input | VID_W | Video error event pulses, one bit per error type |
| aud_err_evt | input | AUD_W | Audio error event pulses |
| field_start | input | 1 | Start-of-field pulse |
| link_locked | input | 1 | Receiver lock; low clears status |
| proc_enable | input | 1 | Processing enable; low clears status |
| std_change | input | 1 | Video standard change flag; high clears status |
| hd_mode | input | 1 | 1 selects the HD audio mask, 0 selects the SD audio mask |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data |
| vid_err_n | output | 1 | Active-low video error flag |
| aud_err_n | output | 1 | Active-low audio error flag |
| data_err_n | output | 1 | Active-low combined error flag |

## Verification
The bench sweeps every mask value against every single-bit event on both the video side and the audio side, and on the audio side it loads the opposite value into the unselected mask. A design that inverts the mask sense, or that takes its audio mask from the wrong register, fails these sweeps. The bench also places an event in the same cycle as a field start, and again in the same cycle as a status read. A design that clears first and then loses that event reads back zero. Each hard clear is driven together with a new event and must leave the status zero, which exposes a design that gives event capture priority over a hard clear. Reset with nonzero masks, reads of unmapped addresses and writes to the status addresses round out the checks.

// File: rtl/esa_pkg.sv
`timescale 1ns/1ps
package esa_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_VSTAT  = 3'd0,
    A_ASTAT  = 3'd1,
    A_VMASK  = 3'd2,
    A_SDMASK = 3'd3,
    A_HDMASK = 3'd4
  } esa_addr_e;
endpackage

// File: rtl/esa_sticky.sv
`timescale 1ns/1ps
// Sticky status word: set by event pulses, cleared by hard or soft conditions.
module esa_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hard_clr,
  input  logic         soft_clr,
  input  logic [W-1:0] evt,
  output logic [W-1:0] stat_q
);

  always_ff @(posedge clk) begin
    if (rst || hard_clr)
      stat_q <= '0;
    else if (soft_clr)
      stat_q <= evt;            // new events survive a soft clear
    else
      stat_q <= stat_q | evt;
  end

  AST_HARD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    hard_clr |=> stat_q == '0);                                          // R7
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!hard_clr && (|evt)) |=> ((stat_q & $past(evt)) == $past(evt)));    // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hard_clr && !soft_clr && evt == '0) |=> $stable(stat_q));          // R4
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (soft_clr && !hard_clr) |=> stat_q == $past(evt));                   // R5

endmodule

// File: rtl/esa_host_regs.sv
`timescale 1ns/1ps
// Mask registers, read mux and read-clear strobes.
module esa_host_regs #(
  parameter int VID_W  = 8,
  parameter int AUD_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [esa_pkg::ADDR_W-1:0] addr,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     hd_mode,
  input  logic [VID_W-1:0]         vstat,
  input  logic [AUD_W-1:0]         astat,
  output logic [VID_W-1:0]         vmask,
  output logic [AUD_W-1:0]         amask_sel,
  output logic                     vstat_rd_clr,
  output logic                     astat_rd_clr,
  output logic [DATA_W-1:0]        rdata
);
  import esa_pkg::*;

  logic [AUD_W-1:0]  sd_mask, hd_mask;
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      vmask   <= '0;
      sd_mask <= '0;
      hd_mask <= '0;
    end else if (wr) begin
      case (addr)
        A_VMASK:  vmask   <= wdata[VID_W-1:0];
        A_SDMASK: sd_mask <= wdata[AUD_W-1:0];
        A_HDMASK: hd_mask <= wdata[AUD_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    case (addr)
      A_VSTAT:  rdata_d = DATA_W'(vstat);
      A_ASTAT:  rdata_d = DATA_W'(astat);
      A_VMASK:  rdata_d = DATA_W'(vmask);
      A_SDMASK: rdata_d = DATA_W'(sd_mask);
      A_HDMASK: rdata_d = DATA_W'(hd_mask);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rdata_d;
  end

  assign amask_sel    = hd_mode ? hd_mask : sd_mask;
  assign vstat_rd_clr = rd && (addr == A_VSTAT);
  assign astat_rd_clr = rd && (addr == A_ASTAT);

  AST_MASK_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (vmask == '0 && sd_mask == '0 && hd_mask == '0));    // R1
  AST_SD_KEPT: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == A_SDMASK) |=> $stable(sd_mask));                     // R9
  AST_HD_KEPT: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == A_HDMASK) |=> $stable(hd_mask));                     // R9

endmodule

// File: rtl/esa_gate.sv
`timescale 1ns/1ps
// Registered active-low flags from masked status.
module esa_gate #(
  parameter int VID_W = 8,
  parameter int AUD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VID_W-1:0] vstat,
  input  logic [VID_W-1:0] vmask,
  input  logic [AUD_W-1:0] astat,
  input  logic [AUD_W-1:0] amask,
  output logic             vid_err_n,
  output logic             aud_err_n,
  output logic             data_err_n
);

  logic v_hit, a_hit;

  assign v_hit = |(vstat & ~vmask);
  assign a_hit = |(astat & ~amask);

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_err_n  <= 1'b1;
      aud_err_n  <= 1'b1;
      data_err_n <= 1'b1;
    end else begin
      vid_err_n  <= ~v_hit;
      aud_err_n  <= ~a_hit;
      data_err_n <= ~(v_hit | a_hit);
    end
  end

  AST_DATA_SUM: assert property (@(posedge clk) disable iff (rst)
    data_err_n == (vid_err_n & aud_err_n));                              // R8
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (vstat == '0 && astat == '0) |=> (vid_err_n && aud_err_n));          // R2

endmodule

// File: rtl/err_status_agg.sv
`timescale 1ns/1ps
module err_status_agg #(
  parameter int VID_W  = 8,
  parameter int AUD_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [VID_W-1:0]           vid_err_evt,
  input  logic [AUD_W-1:0]           aud_err_evt,
  input  logic                       field_start,
  input  logic                       link_locked,
  input  logic                       proc_enable,
  input  logic                       std_change,
  input  logic                       hd_mode,
  input  logic [esa_pkg::ADDR_W-1:0] host_addr,
  input  logic                       host_wr,
  input  logic                       host_rd,
  input  logic [DATA_W-1:0]          host_wdata,
  output logic [DATA_W-1:0]          host_rdata,
  output logic                       vid_err_n,
  output logic                       aud_err_n,
  output logic                       data_err_n
);

  logic             hard_clr;
  logic             vrd_clr, ard_clr;
  logic [VID_W-1:0] vid_stat, vid_mask;
  logic [AUD_W-1:0] aud_stat, aud_mask;

  assign hard_clr = !link_locked || !proc_enable || std_change;

  esa_sticky #(.W(VID_W)) u_vstat (
    .clk(clk), .rst(rst), .hard_clr(hard_clr),
    .soft_clr(field_start || vrd_clr), .evt(vid_err_evt), .stat_q(vid_stat));

  esa_sticky #(.W(AUD_W)) u_astat (
    .clk(clk), .rst(rst), .hard_clr(hard_clr),
    .soft_clr(field_start || ard_clr), .evt(aud_err_evt), .stat_q(aud_stat));

  esa_host_regs #(.VID_W(VID_W), .AUD_W(AUD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .wdata(host_wdata), .hd_mode(hd_mode), .vstat(vid_stat), .astat(aud_stat),
    .vmask(vid_mask), .amask_sel(aud_mask), .vstat_rd_clr(vrd_clr),
    .astat_rd_clr(ard_clr), .rdata(host_rdata));

  esa_gate #(.VID_W(VID_W), .AUD_W(AUD_W)) u_gate (
    .clk(clk), .rst(rst), .vstat(vid_stat), .vmask(vid_mask),
    .astat(aud_stat), .amask(aud_mask), .vid_err_n(vid_err_n),
    .aud_err_n(aud_err_n), .data_err_n(data_err_n));

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (vrd_clr && !hard_clr) |=> ((vid_stat & ~$past(vid_err_evt)) == '0)); // R6

endmodule

// File: tb/err_status_agg_test.sv
`timescale 1ns/1ps
module err_status_agg_test;
  import esa_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] vid_err_evt = '0, aud_err_evt = '0;
  logic       field_start = 0, link_locked = 1, proc_enable = 1, std_change = 0;
  logic       hd_mode = 0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       vid_err_n, aud_err_n, data_err_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  err_status_agg uut (
    .clk(clk), .rst(rst), .vid_err_evt(vid_err_evt), .aud_err_evt(aud_err_evt),
    .field_start(field_start), .link_locked(link_locked), .proc_enable(proc_enable),
    .std_change(std_change), .hd_mode(hd_mode), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .vid_err_n(vid_err_n), .aud_err_n(aud_err_n),
    .data_err_n(data_err_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    step();
    host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_rd = 1; host_addr = a;
    step();
    host_rd = 0;
    d = host_rdata;
  endtask

  task automatic pulse_v(input logic [7:0] v);
    vid_err_evt = v; step(); vid_err_evt = '0;
  endtask

  task automatic pulse_a(input logic [7:0] v);
    aud_err_evt = v; step(); aud_err_evt = '0;
  endtask

  task automatic fclear();
    field_start = 1; step(); field_start = 0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) step();
    rst = 0;
    step();
    // reset state
    chk("R2 vid idle", vid_err_n, 1);
    chk("R2 aud idle", aud_err_n, 1);
    chk("R2 data idle", data_err_n, 1);
    rd(A_VMASK, d);  chk("R1 vmask", d, 0);
    rd(A_SDMASK, d); chk("R1 sdmask", d, 0);
    rd(A_HDMASK, d); chk("R1 hdmask", d, 0);
    rd(A_VSTAT, d);  chk("R4 vstat reset", d, 0);

    // R3 / R8 video sweep
    for (int m = 0; m < 256; m++) begin
      for (int i = 0; i < 8; i++) begin
        logic exp_n;
        wr(A_VMASK, 8'(m));
        pulse_v(8'(1 << i));
        step();
        exp_n = m[i];
        chk("R3 vid flag", vid_err_n, exp_n);
        chk("R8 data flag", data_err_n, exp_n);
        fclear();
      end
    end
    wr(A_VMASK, 8'h00);
    step();

    // R9 audio sweep with opposite value in the unselected mask
    for (int m = 0; m < 256; m++) begin
      for (int i = 0; i < 8; i++) begin
        logic h;
        h = logic'((m + i) & 1);
        hd_mode = h;
        wr(A_SDMASK, h ? ~8'(m) : 8'(m));
        wr(A_HDMASK, h ? 8'(m) : ~8'(m));
        pulse_a(8'(1 << i));
        step();
        chk("R9 aud flag", aud_err_n, m[i]);
        chk("R8 data from aud", data_err_n, m[i]);
        chk("R8 vid quiet", vid_err_n, 1);
        fclear();
      end
    end

    // R9 mode switch with status held
    wr(A_SDMASK, 8'hFF); wr(A_HDMASK, 8'h00);
    hd_mode = 0;
    pulse_a(8'h10); step();
    chk("R9 sd mask hides", aud_err_n, 1);
    hd_mode = 1; step(); step();
    chk("R9 hd mask shows", aud_err_n, 0);
    chk("R8 data shows", data_err_n, 0);
    rd(A_SDMASK, d); chk("R9 sd mask kept", d, 8'hFF);
    rd(A_ASTAT, d);  chk("R6 astat read", d, 8'h10);
    step();
    chk("R6 aud cleared by read", aud_err_n, 1);
    hd_mode = 0;

    // R4 sticky hold
    pulse_v(8'h08);
    repeat (20) step();
    chk("R4 held flag", vid_err_n, 0);
    rd(A_VMASK, d); chk("R10 mask read no clear", vid_err_n, 0);
    // R6 read with same-cycle event
    host_rd = 1; host_addr = A_VSTAT; vid_err_evt = 8'h04;
    step();
    host_rd = 0; vid_err_evt = '0;
    chk("R6 read value", host_rdata, 8'h08);
    rd(A_VSTAT, d); chk("R6 event survives read", d, 8'h04);
    rd(A_VSTAT, d); chk("R6 cleared", d, 8'h00);
    step();
    chk("R6 flag cleared", vid_err_n, 1);

    // R5 field start with same-cycle event
    pulse_v(8'h02);
    field_start = 1; vid_err_evt = 8'h20;
    step();
    field_start = 0; vid_err_evt = '0;
    rd(A_VSTAT, d); chk("R5 field clear keeps new", d, 8'h20);

    // R7 hard clears with same-cycle events
    for (int k = 0; k < 3; k++) begin
      pulse_v(8'h81); pulse_a(8'h42);
      vid_err_evt = 8'h10; aud_err_evt = 8'h01;
      if (k == 0) link_locked = 0;
      if (k == 1) proc_enable = 0;
      if (k == 2) std_change = 1;
      step();
      link_locked = 1; proc_enable = 1; std_change = 0;
      vid_err_evt = '0; aud_err_evt = '0;
      step();
      chk("R7 hard clear vid flag", vid_err_n, 1);
      chk("R7 hard clear aud flag", aud_err_n, 1);
      rd(A_VSTAT, d); chk("R7 vstat zero", d, 0);
      rd(A_ASTAT, d); chk("R7 astat zero", d, 0);
    end

    // R10 map: unmapped reads and status writes
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R10 unmapped read", d, 0);
    end
    wr(A_VSTAT, 8'hFF); wr(A_ASTAT, 8'hFF);
    step();
    rd(A_VSTAT, d); chk("R10 vstat write ignored", d, 0);
    rd(A_ASTAT, d); chk("R10 astat write ignored", d, 0);
    chk("R10 flag unchanged", data_err_n, 1);

    // R7 / R1 reset clears status and masks
    wr(A_VMASK, 8'h5A); wr(A_HDMASK, 8'hA5);
    pulse_v(8'h01);
    rst = 1; step(); step(); rst = 0; step();
    rd(A_VMASK, d);  chk("R1 vmask after reset", d, 0);
    rd(A_HDMASK, d); chk("R1 hdmask after reset", d, 0);
    rd(A_VSTAT, d);  chk("R7 reset clears status", d, 0);
    chk("R2 flags after reset", {vid_err_n, aud_err_n, data_err_n}, 3'b111);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule